// File: doc/BRIEF.md
# Bitmap Position-Automaton Regular Expression Matcher

This block runs a position automaton for one regular expression over a byte stream. Every symbol position of the expression owns one bit. An active-position register tracks which positions are live. Four programmable tables hold the behaviour of the expression:

- a start bitmap, with the positions that can begin a match;
- a final bitmap, with the positions that complete a match;
- one successor bitmap for each position;
- one admit bitmap for each symbol class.

A 256-entry byte-to-class map comes before the admit lookup. Bytes that are never programmed fall into class 0, which stands for "any other byte".

For every consumed byte the block forms a union: the start bitmap (when start is permitted) together with the successor rows of all live positions. It then masks that union with the admit row of the byte's class. The successor rows are read one live position per cycle, and the input is stalled until the walk finishes. A byte flagged as end of string produces a one-cycle verdict. After the verdict the live set is cleared, ready for the next string. An anchored mode lets a match start only at the first byte of a string. A line mode treats a chosen byte as a line break that returns the automaton to its start state.

Top module: `regex_bitmap_nfa`

## Requirements
- R1: After reset, `in_ready` is 1, `acc_valid` is 0 and no position is live.
- R2: Tables are written while `prog_we` is 1, with the table chosen by `prog_sel`:
  - 0: class map, with entry `prog_addr` set to `prog_data[CW-1:0]`;
  - 1: start bitmap;
  - 2: final bitmap;
  - 3: successor row of position `prog_addr`;
  - 4: admit row of class `prog_addr`.
  
  Bit i of any bitmap stands for position i. Every byte maps to class 0 until it is written. Class 0 admits nothing unless its row is programmed, so an unmapped byte empties the live set.
- R3: For each consumed byte, the new live set is (start bitmap if start is permitted, OR every successor row of the current live positions) AND the admit row of the byte's class.
- R4: After a byte is consumed (that is not a line-mode break), `in_ready` is 0 for exactly popcount(live set)+1 cycles, then returns to 1.
- R5: With `mode_anchored`=0, start is permitted on every byte, so a match may begin at any offset.
- R6: With `mode_anchored`=1, start is permitted only on the first byte after reset, after an end of string, or after a line break.
- R7: When the end-of-string byte finishes its walk, `acc_valid` is 1 for exactly one cycle. At the same time `acc_match` equals 1 exactly when the new live set intersects the final bitmap. The live set is then empty for the next string.
- R8: With `mode_line`=1, a byte equal to `newline_sym` is consumed in one cycle with no stall. It empties the live set and permits start again. If that byte also ends the string, it produces `acc_valid` with `acc_match`=0 on the next cycle.
- R9: Bytes mapped to the same class give identical results, so case-insensitive matching is obtained by mapping both cases of a letter to one class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_we | input | 1 | Table write strobe |
| prog_sel | input | 3 | Table select (0 map, 1 start, 2 final, 3 successor, 4 admit) |
| prog_addr | input | SYMW | Byte, position or class index of the write |
| prog_data | input | NPOS | Bitmap or class value written |
| mode_anchored | input | 1 | Start permitted only at string/line start |
| mode_line | input | 1 | Line break resets the automaton |
| newline_sym | input | SYMW | Byte treated as line break |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_sym | input | SYMW | Input byte |
| in_last | input | 1 | Byte ends the string |
| acc_valid | output | 1 | Verdict pulse |
| acc_match | output | 1 | Verdict: string accepted |

## Verification
The end-of-string verdict and the line-break reset can both happen on the same byte when a string ends in a break in line mode. The bench provokes this by ending a string whose prefix already reached a final position with the break byte. It requires a no-stall, non-matching verdict on the following cycle. A second coincidence is the verdict landing on the same edge that empties the live set. The bench checks this by sending a byte that would extend the previous string's match as a new string of its own, and requiring no match. Every stall cycle and every verdict is compared on each clock against a behavioural model of the tables.

// File: rtl/regex_bitmap_nfa.sv
module regex_bitmap_nfa #(
  parameter int SYMW   = 8,
  parameter int NPOS   = 16,
  parameter int NCLASS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [2:0]      prog_sel,
  input  logic [SYMW-1:0] prog_addr,
  input  logic [NPOS-1:0] prog_data,
  input  logic            mode_anchored,
  input  logic            mode_line,
  input  logic [SYMW-1:0] newline_sym,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [SYMW-1:0] in_sym,
  input  logic            in_last,
  output logic            acc_valid,
  output logic            acc_match
);
  localparam int NSYM = 1 << SYMW;
  localparam int CW   = $clog2(NCLASS);
  localparam int IW   = $clog2(NPOS);

  logic [CW-1:0]   cmap   [NSYM];
  logic [NPOS-1:0] follow [NPOS];
  logic [NPOS-1:0] enter  [NCLASS];
  logic [NPOS-1:0] first_bm, last_bm;

  logic [NPOS-1:0] b, mask, accum, nb;
  logic [CW-1:0]   cls_q;
  logic            walking, eos_q, at_start;
  logic [IW-1:0]   low_idx;
  logic            is_break;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSYM; i++) cmap[i] <= '0;
      for (int i = 0; i < NPOS; i++) follow[i] <= '0;
      for (int i = 0; i < NCLASS; i++) enter[i] <= '0;
      first_bm <= '0;
      last_bm  <= '0;
    end else if (prog_we) begin
      case (prog_sel)
        3'd0: cmap[prog_addr] <= prog_data[CW-1:0];
        3'd1: first_bm <= prog_data;
        3'd2: last_bm  <= prog_data;
        3'd3: if (int'(prog_addr) < NPOS) follow[prog_addr[IW-1:0]] <= prog_data;
        3'd4: if (int'(prog_addr) < NCLASS) enter[prog_addr[CW-1:0]] <= prog_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    low_idx = '0;
    for (int i = NPOS - 1; i >= 0; i--)
      if (mask[i]) low_idx = IW'(i);
  end

  assign nb       = accum & enter[cls_q];
  assign in_ready = !walking;
  assign is_break = mode_line && (in_sym == newline_sym);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b         <= '0;
      mask      <= '0;
      accum     <= '0;
      cls_q     <= '0;
      eos_q     <= 1'b0;
      walking   <= 1'b0;
      at_start  <= 1'b1;
      acc_valid <= 1'b0;
      acc_match <= 1'b0;
    end else begin
      acc_valid <= 1'b0;
      if (!walking) begin
        if (in_valid) begin
          if (is_break) begin
            b        <= '0;
            at_start <= 1'b1;
            if (in_last) begin
              acc_valid <= 1'b1;
              acc_match <= 1'b0;
            end
          end else begin
            walking  <= 1'b1;
            mask     <= b;
            accum    <= (!mode_anchored || at_start) ? first_bm : '0;
            cls_q    <= cmap[in_sym];
            eos_q    <= in_last;
            at_start <= 1'b0;
          end
        end
      end else if (mask != '0) begin
        accum <= accum | follow[low_idx];
        mask  <= mask & ~(NPOS'(1) << low_idx);
      end else begin
        walking <= 1'b0;
        if (eos_q) begin
          acc_valid <= 1'b1;
          acc_match <= |(nb & last_bm);
          b         <= '0;
          at_start  <= 1'b1;
        end else begin
          b <= nb;
        end
      end
    end
  end
endmodule

// File: rtl/regex_bitmap_nfa_chk.sv
module regex_bitmap_nfa_chk #(
  parameter int NPOS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            acc_valid,
  input logic            acc_match,
  input logic            walking,
  input logic [NPOS-1:0] mask,
  input logic [NPOS-1:0] b,
  input logic [NPOS-1:0] last_bm
);
  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> !in_ready); // R4
  AST_WALK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && mask != '0) |=> ($countones(mask) + 1 == $countones($past(mask)))); // R4
  AST_LIVE_HELD_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && mask != '0) |=> $stable(b)); // R3
  AST_VERDICT_CLEARS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (b == '0)); // R7
  AST_MATCH_NEEDS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_match) |-> (last_bm != '0)); // R7
endmodule

bind regex_bitmap_nfa regex_bitmap_nfa_chk #(.NPOS(NPOS)) i_chk (.*);

// File: tb/test_regex_bitmap_nfa.sv
`timescale 1ns/1ps
module test_regex_bitmap_nfa;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [2:0] prog_sel = '0;
  logic [7:0] prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic mode_anchored = 1'b0, mode_line = 1'b0;
  logic [7:0] newline_sym = 8'h0A;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_sym = '0;
  logic in_ready, acc_valid, acc_match;

  always #2.5 clk = ~clk;

  regex_bitmap_nfa i_regex_bitmap_nfa (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  int cmap_m[256];
  logic [15:0] follow_m[16];
  logic [15:0] enter_m[8];
  logic [15:0] first_m = '0, last_m = '0, b_m = '0;
  bit start_m = 1;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic prog(input int sel, input int addr, input logic [15:0] data);
    @(negedge clk);
    prog_we = 1; prog_sel = 3'(sel); prog_addr = 8'(addr); prog_data = data;
    @(negedge clk);
    prog_we = 0;
    case (sel)
      0: cmap_m[addr] = int'(data[2:0]);
      1: first_m = data;
      2: last_m = data;
      3: follow_m[addr] = data;
      4: enter_m[addr] = data;
      default: ;
    endcase
  endtask

  task automatic send(input logic [7:0] s, input bit eos, input string req);
    int cnt;
    bit brk, exp_m;
    logic [15:0] acc;
    brk = mode_line && (s == newline_sym);
    exp_m = 0;
    cnt = 0;
    if (brk) begin
      b_m = '0; start_m = 1;
    end else begin
      cnt = $countones(b_m);
      acc = (!mode_anchored || start_m) ? first_m : '0;
      for (int i = 0; i < 16; i++) if (b_m[i]) acc = acc | follow_m[i];
      acc = acc & enter_m[cmap_m[s]];
      start_m = 0;
      if (eos) begin
        exp_m = |(acc & last_m); b_m = '0; start_m = 1;
      end else b_m = acc;
    end
    @(negedge clk);
    chk(in_ready == 1, "R4 idle ready", int'(in_ready), 1);
    chk(acc_valid == 0, "R7 pulse length", int'(acc_valid), 0);
    in_valid = 1; in_sym = s; in_last = eos;
    @(negedge clk);
    in_valid = 0; in_last = 0;
    if (brk) begin
      chk(in_ready == 1, "R8 no stall on break", int'(in_ready), 1);
      chk(acc_valid == eos, "R8 verdict on break", int'(acc_valid), int'(eos));
      if (eos) chk(acc_match == 0, "R8 break verdict", int'(acc_match), 0);
    end else begin
      for (int i = 0; i <= cnt; i++) begin
        chk(in_ready == 0 && acc_valid == 0, "R4 stall", int'(in_ready), 0);
        @(negedge clk);
      end
      chk(in_ready == 1, "R4 stall end", int'(in_ready), 1);
      chk(acc_valid == eos, "R7 verdict timing", int'(acc_valid), int'(eos));
      if (eos) chk(acc_match == exp_m, req, int'(acc_match), int'(exp_m));
    end
  endtask

  task automatic send_str(input string s, input string req);
    for (int i = 0; i < s.len(); i++) send(s[i], i == s.len() - 1, req);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) cmap_m[i] = 0;
    for (int i = 0; i < 16; i++) follow_m[i] = '0;
    for (int i = 0; i < 8; i++) enter_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1, "R1 ready after reset", int'(in_ready), 1);
    chk(acc_valid == 0, "R1 no verdict after reset", int'(acc_valid), 0);
    // expression (AB|CA)(ADB|CEF)*, positions 0..9 as bits
    for (int c = 0; c < 6; c++) begin
      prog(0, 65 + c, 16'(c + 1));
      prog(0, 97 + c, 16'(c + 1));
    end
    prog(1, 0, 16'h0005);
    prog(2, 0, 16'h024A);
    prog(3, 0, 16'h0002); prog(3, 2, 16'h0008);
    prog(3, 1, 16'h0090); prog(3, 3, 16'h0090);
    prog(3, 6, 16'h0090); prog(3, 9, 16'h0090);
    prog(3, 4, 16'h0020); prog(3, 5, 16'h0040);
    prog(3, 7, 16'h0100); prog(3, 8, 16'h0200);
    prog(4, 1, 16'h0019); prog(4, 2, 16'h0042); prog(4, 3, 16'h0084);
    prog(4, 4, 16'h0020); prog(4, 5, 16'h0100); prog(4, 6, 16'h0200);

    send_str("ABADB", "R3 ABADB match");
    send_str("ABCEF", "R3 ABCEF match");
    send_str("ABC", "R3 ABC no match");
    send_str("zzCA", "R5 unanchored offset match");
    send_str("CAB", "R5 unanchored restart");
    send_str("AzB", "R2 other class kills");
    send_str("ab", "R9 lower case match");
    send_str("cEf", "R9 mixed case no match");
    send_str("A", "R7 single A");
    send_str("B", "R7 live set cleared");

    mode_anchored = 1;
    send_str("xAB", "R6 anchored offset rejected");
    send_str("AB", "R6 anchored start match");
    send_str("CAAdB", "R6 anchored continuation");

    mode_line = 1;
    send_str("zz\nCA", "R8 break restarts anchor");
    send_str("AB\n", "R8 break ends string");
    send_str("A\nB", "R8 break clears live");
    mode_anchored = 0;
    send_str("AB\nAB", "R8 unanchored break");

    done = 1;
    summary;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R4 watchdog got=hung expected=finished");
      summary;
      $finish;
    end
  end
endmodule